// File: doc/BRIEF.md
# Write-only I2C slave receiver

This block is an I2C-bus slave that can only be written to. It brings the bus clock and data lines into the system clock domain through a short synchronizer chain and finds their edges there. It recognises START and STOP conditions, compares the first byte of every transfer with a fixed 6-bit address prefix extended by one strap pin, and acknowledges the address only when the direction bit requests a write. Every byte that follows in an accepted transfer is acknowledged and handed to downstream logic on a parallel bus with a one-cycle strobe. A flag on that strobe marks the first byte after the address.

Both bus lines are treated as open-drain. The block never drives a level; it only outputs pull-low enables. The data pull is used for nothing except acknowledge bits. The clock pull stretches the bus clock whenever downstream logic raises its busy input at the end of an acknowledge, so that no byte is lost. The slave never starts a transfer, and it ignores read requests and foreign addresses until the next START or STOP.

Top module: `wo_i2c_rx`

## Requirements
- R1: While reset is held and right after it, scl_pull, sda_pull, rx_valid and rx_first are all 0.
- R2: An address byte whose upper seven bits equal {ADDR_BASE, addr_strap} (default 0111110 when the strap is 0, 0111111 when it is 1) and whose last bit (direction, 0 = write) is 0 is acknowledged: SDA is low during the 9th SCL high phase.
- R3: An address byte with other upper bits, or with the direction bit at 1, is not acknowledged, and no data byte of that transfer is acknowledged or presented.
- R4: In an accepted transfer each data byte is shifted in MSB first, appears on rx_data with rx_valid high for exactly one clock after its 8th SCL rising edge, and is acknowledged.
- R5: rx_first is high, together with rx_valid, only for the first data byte after an accepted address. It is low otherwise.
- R6: sda_pull changes only while the synchronized SCL is low. It is high only from the SCL falling edge after the 8th bit until the falling edge that ends the 9th bit.
- R7: If busy is high at the SCL falling edge that ends an acknowledge, scl_pull holds SCL low until busy falls. It is released on the first clock after busy is seen low, and the next bytes are still received intact. scl_pull is never high unless busy was high.
- R8: A repeated START in the middle of a transfer returns the block to the address phase, and the next accepted address restarts rx_first.
- R9: A STOP returns the block to idle. Bits clocked after a STOP without a new START are neither acknowledged nor presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| addr_strap | input | 1 | Least significant address bit, tied by the board |
| busy | input | 1 | Downstream logic cannot take another byte yet |
| scl_pull | output | 1 | Pull-low enable for the bus clock line |
| sda_pull | output | 1 | Pull-low enable for the bus data line (acknowledge only) |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte on rx_data |
| rx_first | output | 1 | The strobed byte is the first after the address |

## Verification
The bench targets four failure points. It sends the address that belongs to the other strap value, so a design that ignores the strap acknowledges it. It sends a read to the matching address, so a design that skips the direction bit acknowledges and presents data. It sends a repeated START partway through a transfer, so a design that stays in data mode delivers the new address as data or loses the first-byte flag. Finally it holds busy across an acknowledge and then sends more bytes: a design that releases SCL early, or one that drops a bit while SCL is held, shows either a clock pull with busy low or a byte that does not match the sent one.

// File: rtl/wo_i2c_pkg.sv
package wo_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int PFX_W  = BYTE_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } rx_state_t;

  // Address byte accepted: upper seven bits equal prefix plus strap, write direction.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [PFX_W-1:0]  base,
                                    input logic              strap);
    return (b[BYTE_W-1:1] == {base, strap}) && !b[0];
  endfunction

endpackage

// File: rtl/wo_i2c_sync.sv
module wo_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/wo_i2c_fsm.sv
module wo_i2c_fsm
  import wo_i2c_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_BASE = 6'b011111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              addr_strap,
  input  logic              busy,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_first
);

  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg;
  logic              first_pend;

  logic [BYTE_W-1:0] nxt_byte;
  logic              last_bit;
  logic              byte_end;

  assign nxt_byte = {shreg[BYTE_W-2:0], sda_s};
  assign last_bit = (cnt == LAST);
  assign byte_end = scl_fall && (cnt == FULL);
  assign scl_pull = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_first   <= 1'b0;
      first_pend <= 1'b0;
      sda_pull   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_first <= 1'b0;
      if (stop_ev) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_ev) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= nxt_byte;
              if (last_bit && !addr_hit(nxt_byte, ADDR_BASE, addr_strap))
                state <= ST_SKIP;
              else
                cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              state      <= ST_ACK;
              sda_pull   <= 1'b1;
              first_pend <= 1'b1;
            end
          end
          ST_DATA: begin
            if (scl_rise) begin
              shreg <= nxt_byte;
              cnt   <= cnt + 1'b1;
              if (last_bit) begin
                rx_data    <= nxt_byte;
                rx_valid   <= 1'b1;
                rx_first   <= first_pend;
                first_pend <= 1'b0;
              end
            end else if (byte_end) begin
              state    <= ST_ACK;
              sda_pull <= 1'b1;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              state    <= busy ? ST_HOLD : ST_DATA;
            end
          end
          ST_HOLD: begin
            if (!busy) state <= ST_DATA;
          end
          default: ;
        endcase
      end
    end

  // R6
  sda_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  // R6
  sda_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_s);

  // R7
  hold_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> $past(busy));

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && !busy) |=> !scl_pull);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  first_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_first |-> rx_valid);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_pull && !scl_pull && !rx_valid));

endmodule

// File: rtl/wo_i2c_rx.sv
module wo_i2c_rx
  import wo_i2c_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_BASE   = 6'b011111,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  input  logic              busy,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_first
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  wo_i2c_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  wo_i2c_fsm #(.ADDR_BASE(ADDR_BASE)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .addr_strap (addr_strap),
    .busy       (busy),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_first   (rx_first)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!scl_pull && !sda_pull && !rx_valid && !rx_first));

endmodule

// File: tb/test_wo_i2c_rx.sv
`timescale 1ns/1ps
module test_wo_i2c_rx;

  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_strap = 1'b0;
  logic busy = 1'b0, busy_d = 1'b0;
  logic scl_pull, sda_pull, rx_valid, rx_first;
  logic [7:0] rx_data;
  logic scl_line, sda_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit ack_win = 1'b0;
  bit accepting = 1'b0;
  bit first_exp = 1'b0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  wo_i2c_rx i_wo_i2c_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .addr_strap(addr_strap), .busy(busy),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_first(rx_first)
  );

  always @(posedge clk) busy_d <= busy;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference decision, restated: seven-bit value 0x3E or'ed with the strap, even byte.
  function automatic bit ref_accept(input logic [7:0] b, input logic strap);
    return ((int'(b) >> 1) == (32'h3E | int'(strap))) && ((int'(b) % 2) == 0);
  endfunction

  // Per-clock comparison against the behavioural model.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected byte", int'(rx_data), 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check(rx_data == e[7:0], "R4 data", int'(rx_data), int'(e[7:0]));
          check(rx_first == e[8], "R5 first flag", int'(rx_first), int'(e[8]));
        end
      end else if (rx_first) check(1'b0, "R5 first without valid", 1, 0);
      if (sda_pull) check(ack_win, "R6 sda pull outside ack", 1, 0);
      if (scl_pull) check(busy || busy_d, "R7 scl pull without busy", 1, 0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wait_clk(H);
    scl_m = 1'b1; wait (scl_line === 1'b1); wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) ack_win = 1'b1;
      send_bit(b[i]);
    end
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait (scl_line === 1'b1); wait_clk(H/2);
    acked = !sda_line; wait_clk(H/2);
    scl_m = 1'b0; wait_clk(H);
    ack_win = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
    accepting = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] b, input string req);
    bit a, e;
    e = ref_accept(b, addr_strap);
    send_byte(b, a);
    check(a == e, req, int'(a), int'(e));
    accepting = e;
    first_exp = e;
  endtask

  task automatic send_data(input logic [7:0] b, input string req);
    bit a;
    if (accepting) begin
      exp_q.push_back({first_exp, b});
      first_exp = 1'b0;
    end
    send_byte(b, a);
    check(a == accepting, req, int'(a), int'(accepting));
  endtask

  initial begin
    bit a;
    wait_clk(4);
    check(!scl_pull && !sda_pull && !rx_valid && !rx_first, "R1 in reset",
          int'({scl_pull, sda_pull, rx_valid, rx_first}), 0);
    rst_n = 1'b1;
    wait_clk(4);
    check(!scl_pull && !sda_pull && !rx_valid, "R1 after reset",
          int'({scl_pull, sda_pull, rx_valid}), 0);

    // R2 R4 R5: strap 0, address 0111110 write, two bytes
    addr_strap = 1'b0;
    bus_start();
    send_addr(8'h7C, "R2 ack strap0");
    send_data(8'hA5, "R4 ack byte1");
    send_data(8'h3C, "R4 ack byte2");
    bus_stop();  // R9

    // R3: address of the other strap value
    bus_start();
    send_addr(8'h7E, "R3 wrong strap address");
    send_data(8'h55, "R3 byte after miss");
    bus_stop();

    // R2 R8: strap 1, repeated START mid-transfer
    addr_strap = 1'b1;
    bus_start();
    send_addr(8'h7E, "R2 ack strap1");
    send_data(8'h81, "R4 byte before restart");
    bus_start();
    send_addr(8'h7E, "R8 ack after restart");
    send_data(8'h0F, "R8 first byte after restart");
    send_data(8'hF0, "R4 second byte after restart");
    bus_stop();

    // R3: read to the matching address
    bus_start();
    send_addr(8'h7F, "R3 read not acked");
    send_data(8'hC3, "R3 byte after read");
    bus_stop();

    // R3: unrelated address
    bus_start();
    send_addr(8'h42, "R3 foreign address");
    bus_stop();

    // R7: stretch after the acknowledge of a data byte
    bus_start();
    send_addr(8'h7E, "R7 address");
    @(negedge clk) busy = 1'b1;
    send_data(8'h96, "R7 byte before stretch");
    check(scl_pull && !scl_line, "R7 clock held", int'(scl_pull), 1);
    wait_clk(30);
    check(scl_pull, "R7 clock still held", int'(scl_pull), 1);
    busy = 1'b0;
    @(negedge clk);
    check(!scl_pull, "R7 released next cycle", int'(scl_pull), 0);
    send_data(8'h42, "R7 byte after stretch");
    send_data(8'h01, "R7 second byte after stretch");
    bus_stop();

    // R9: bits without a START after STOP
    scl_m = 1'b0; wait_clk(H);
    send_byte(8'h7E, a);
    check(!a, "R9 no ack after stop", int'(a), 0);
    send_byte(8'h99, a);
    check(!a, "R9 no ack on loose byte", int'(a), 0);
    bus_stop();

    wait_clk(10);
    check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule